// File: doc/BRIEF.md
# Burst Address Sequencer with Two Load Strobes

This block produces the word address presented to the array of a synchronous burst memory. An external address is captured whenever either of two active-low load strobes is seen low at a rising clock edge while the chip-select qualifier is high. One strobe is the processor-side strobe and the other is the controller-side strobe. After a load, the block generates the rest of the burst itself. It steps a two-bit count on every edge at which the active-low advance input is low.

The count is mapped onto the two low address bits in one of two orders. Interleaved order XORs the loaded low bits with the count. Linear order adds the count to the loaded low bits modulo four. The upper address bits are never touched during a burst. The order pin is sampled together with the address, so one burst always follows one order. After the fourth word has been consumed, one more advance ends the burst. The address then stays on the last word until the next load.

Top module: `burst_addr_seq`

## Requirements
- R1: After reset, `mem_addr_o` is zero and `burst_act_o` is low, and both stay so until the first load.
- R2: A load occurs on a rising edge where `chip_sel_i` is 1 and `proc_strb_n_i` or `ctrl_strb_n_i` is 0 (either alone or both). From the next cycle on, `mem_addr_o` equals the captured `addr_i` and `burst_act_o` is 1.
- R3: While `burst_act_o` is 1 and no load occurs, each edge with `adv_n_i` = 0 moves the burst to its next word.
- R4: While no load occurs and `adv_n_i` = 1, `mem_addr_o` and `burst_act_o` hold their values.
- R5: With `order_sel_i` = 1 at load (interleaved), word k of the burst (k = 0..3) has low two bits equal to the loaded low two bits XOR k.
- R6: With `order_sel_i` = 0 at load (linear), word k has low two bits equal to (loaded low two bits + k) mod 4, so the burst wraps within its aligned group of four. In both orders, bits above bit 1 stay equal to the loaded address.
- R7: When `chip_sel_i` = 0, both strobes are ignored, and the address and burst flag are unchanged by them.
- R8: A load during an active burst captures the new address and restarts the burst at word 0.
- R9: An advance taken on the fourth word clears `burst_act_o` and leaves `mem_addr_o` on that fourth word. Advances while `burst_act_o` is 0 have no effect.
- R10: The order is fixed at load time. A change of `order_sel_i` during a burst does not alter the addresses of that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr_i | input | ADDR_W (19) | External word address |
| proc_strb_n_i | input | 1 | Processor-side load strobe, active low |
| ctrl_strb_n_i | input | 1 | Controller-side load strobe, active low |
| adv_n_i | input | 1 | Burst advance, active low |
| order_sel_i | input | 1 | 1 = interleaved order, 0 = linear order |
| chip_sel_i | input | 1 | Chip-select qualifier, active high |
| mem_addr_o | output | ADDR_W (19) | Current array word address |
| burst_act_o | output | 1 | High while a burst has words left to step through |

## Verification
A corrupted count shows at once in the low two bits of `mem_addr_o`, on the cycle after the edge that wrote it. A wrong captured base shows in the upper bits, or in the start word of every order. A stuck or missing active flag shows as an advance that is ignored, or as a fifth step that should not happen. Such faults therefore become visible no later than the end of the four-word burst in which they arise. The sweep walks every start position in both orders with both strobes, so a mapping error confined to one start value or one order cannot go unseen.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } burst_order_e;
endpackage

// File: rtl/bas_rst_sync.sv
module bas_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_no = sync_q[1];
endmodule

// File: rtl/bas_load_ctrl.sv
module bas_load_ctrl (
  input  logic proc_strb_n_i,
  input  logic ctrl_strb_n_i,
  input  logic chip_sel_i,
  input  logic adv_n_i,
  output logic load_o,
  output logic step_o
);
  logic proc_req, ctrl_req;

  // processor strobe counts only while selected; controller strobe likewise
  assign proc_req = ~proc_strb_n_i & chip_sel_i;
  assign ctrl_req = ~ctrl_strb_n_i & chip_sel_i;
  assign load_o   = proc_req | ctrl_req;
  // a load overrides any advance in the same cycle
  assign step_o   = ~adv_n_i & ~load_o;
endmodule

// File: rtl/bas_state.sv
module bas_state
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int CNT_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              step_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              order_sel_i,
  output logic [ADDR_W-1:0] base_o,
  output burst_order_e      order_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              act_o
);
  localparam logic [CNT_W-1:0] LAST_CNT = '1;

  logic [ADDR_W-1:0] base_q, base_d;
  burst_order_e      order_q, order_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              act_q, act_d;
  logic              upd_en;

  assign upd_en = load_i | (act_q & step_i);

  always_comb begin
    base_d  = base_q;
    order_d = order_q;
    cnt_d   = cnt_q;
    act_d   = act_q;
    if (load_i) begin
      base_d  = addr_i;
      order_d = burst_order_e'(order_sel_i);
      cnt_d   = '0;
      act_d   = 1'b1;
    end else if (act_q && step_i) begin
      if (cnt_q == LAST_CNT) act_d = 1'b0;
      else                   cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q  <= '0;
      order_q <= ORD_LINEAR;
      cnt_q   <= '0;
      act_q   <= 1'b0;
    end else if (upd_en) begin
      base_q  <= base_d;
      order_q <= order_d;
      cnt_q   <= cnt_d;
      act_q   <= act_d;
    end
  end

  assign base_o  = base_q;
  assign order_o = order_q;
  assign cnt_o   = cnt_q;
  assign act_o   = act_q;

  AST_LOAD_RESTARTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (act_q && cnt_q == '0 && base_q == $past(addr_i))); // R8

  AST_STEP_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q && step_i && cnt_q != LAST_CNT) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R3

  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !step_i) |=> ($stable(cnt_q) && $stable(act_q))); // R4

  AST_END_BURST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q && step_i && cnt_q == LAST_CNT) |=> (!act_q && cnt_q == LAST_CNT)); // R9

  AST_ORDER_FIXED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(order_q)); // R10
endmodule

// File: rtl/bas_map.sv
module bas_map
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int CNT_W  = 2
) (
  input  logic [ADDR_W-1:0] base_i,
  input  burst_order_e      order_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [CNT_W-1:0] lo_lin, lo_int, lo_sel;

  assign lo_lin = base_i[CNT_W-1:0] + cnt_i;

  for (genvar b = 0; b < CNT_W; b++) begin : g_xor
    assign lo_int[b] = base_i[b] ^ cnt_i[b];
  end

  assign lo_sel = (order_i == ORD_INTERLEAVE) ? lo_int : lo_lin;
  assign addr_o = {base_i[ADDR_W-1:CNT_W], lo_sel};
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 19
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              proc_strb_n_i,
  input  logic              ctrl_strb_n_i,
  input  logic              adv_n_i,
  input  logic              order_sel_i,
  input  logic              chip_sel_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              burst_act_o
);
  localparam int CNT_W = 2;

  logic             rst_sync_n;
  logic             load, step;
  logic [ADDR_W-1:0] base;
  burst_order_e     order;
  logic [CNT_W-1:0] cnt;

  bas_rst_sync u_rst (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rst_sync_no(rst_sync_n)
  );

  bas_load_ctrl u_load (
    .proc_strb_n_i(proc_strb_n_i),
    .ctrl_strb_n_i(ctrl_strb_n_i),
    .chip_sel_i   (chip_sel_i),
    .adv_n_i      (adv_n_i),
    .load_o       (load),
    .step_o       (step)
  );

  bas_state #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_state (
    .clk_i      (clk_i),
    .rst_ni     (rst_sync_n),
    .load_i     (load),
    .step_i     (step),
    .addr_i     (addr_i),
    .order_sel_i(order_sel_i),
    .base_o     (base),
    .order_o    (order),
    .cnt_o      (cnt),
    .act_o      (burst_act_o)
  );

  bas_map #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_map (
    .base_i (base),
    .order_i(order),
    .cnt_i  (cnt),
    .addr_o (mem_addr_o)
  );

  AST_UPPER_FIXED: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    !load |=> $stable(mem_addr_o[ADDR_W-1:CNT_W])); // R6

  AST_UNSEL_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (!chip_sel_i && adv_n_i) |=> ($stable(mem_addr_o) && $stable(burst_act_o))); // R7

  AST_LOAD_VISIBLE: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    load |=> (burst_act_o && mem_addr_o == $past(addr_i))); // R2

  AST_IDLE_NO_STEP: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (!burst_act_o && !load) |=> ($stable(mem_addr_o) && !burst_act_o)); // R9
endmodule

// File: tb/burst_addr_seq_tb.sv
`timescale 1ns/1ps
module burst_addr_seq_tb;
  localparam int ADDR_W = 19;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [ADDR_W-1:0] addr;
  logic              p_n, c_n, a_n, ord, sel;
  logic [ADDR_W-1:0] mem_addr;
  logic              act;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  burst_addr_seq #(.ADDR_W(ADDR_W)) u_dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .addr_i       (addr),
    .proc_strb_n_i(p_n),
    .ctrl_strb_n_i(c_n),
    .adv_n_i      (a_n),
    .order_sel_i  (ord),
    .chip_sel_i   (sel),
    .mem_addr_o   (mem_addr),
    .burst_act_o  (act)
  );

  function automatic logic [ADDR_W-1:0] exp_word(input logic [ADDR_W-1:0] b,
                                                 input logic o, input int k);
    logic [1:0] lo;
    lo = o ? (b[1:0] ^ 2'(k)) : 2'((int'(b[1:0]) + k) % 4);
    return {b[ADDR_W-1:2], lo};
  endfunction

  task automatic check(input logic [ADDR_W-1:0] ea, input logic eact, input string req);
    checks++;
    if (mem_addr !== ea || act !== eact) begin
      fails++;
      $display("FAIL %s: addr=%h act=%b expected addr=%h act=%b", req, mem_addr, act, ea, eact);
    end
  endtask

  task automatic cyc(input logic pn, input logic cn, input logic an, input logic s,
                     input logic o, input logic [ADDR_W-1:0] ad);
    @(negedge clk);
    p_n = pn; c_n = cn; a_n = an; sel = s; ord = o; addr = ad;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [ADDR_W-1:0] b;
    rst_n = 1'b0; p_n = 1'b1; c_n = 1'b1; a_n = 1'b1; sel = 1'b0; ord = 1'b1; addr = '0;
    repeat (3) @(posedge clk);
    #1;
    check('0, 1'b0, "R1");
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check('0, 1'b0, "R1");
    cyc(1, 1, 0, 1, 0, 19'h12345);  // advance before any load
    check('0, 1'b0, "R1");

    // sweep: both orders, every start position, both strobes
    for (int o = 0; o < 2; o++) begin
      for (int s = 0; s < 4; s++) begin
        for (int st = 0; st < 2; st++) begin
          b = ADDR_W'((o * 8 + s * 2 + st) * 32771 + 'h1234);
          b[1:0] = 2'(s);
          cyc(st == 0 ? 1'b0 : 1'b1, st == 0 ? 1'b1 : 1'b0, 1, 1, o[0], b);
          check(exp_word(b, o[0], 0), 1'b1, "R2");
          for (int k = 1; k < 4; k++) begin
            cyc(1, 1, 0, 1, ~o[0], '0);
            check(exp_word(b, o[0], k), 1'b1, o[0] ? "R5" : "R6");
            cyc(1, 1, 1, 1, o[0], '1);
            check(exp_word(b, o[0], k), 1'b1, "R4");
          end
          cyc(1, 1, 0, 1, o[0], '0);
          check(exp_word(b, o[0], 3), 1'b0, "R9");
          cyc(1, 1, 0, 1, o[0], '0);
          check(exp_word(b, o[0], 3), 1'b0, "R9");
        end
      end
    end

    // unselected strobes are ignored
    b = 19'h2AAA9;
    cyc(0, 1, 1, 1, 1, b);
    check(b, 1'b1, "R2");
    cyc(0, 0, 1, 0, 0, 19'h05550);
    check(b, 1'b1, "R7");
    cyc(1, 0, 1, 0, 1, 19'h7FFFF);
    check(b, 1'b1, "R7");

    // restart mid-burst
    cyc(1, 1, 0, 1, 1, '0);
    check(exp_word(b, 1, 1), 1'b1, "R3");
    cyc(1, 0, 0, 1, 0, 19'h4C4C6);
    check(19'h4C4C6, 1'b1, "R8");
    cyc(1, 1, 0, 1, 1, '0);
    check(exp_word(19'h4C4C6, 0, 1), 1'b1, "R8");

    // order captured at load only
    cyc(0, 0, 1, 1, 1, 19'h00011);
    check(19'h00011, 1'b1, "R10");
    cyc(1, 1, 0, 1, 0, '0);
    check(exp_word(19'h00011, 1, 1), 1'b1, "R10");
    cyc(1, 1, 0, 1, 0, '0);
    check(exp_word(19'h00011, 1, 2), 1'b1, "R10");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule